// File: doc/BRIEF.md
# Reference Time Counters

This block keeps two free-running, read-only time registers that run off a reference clock. One holds the number of whole seconds that have passed since the last cold reset. The other holds how many 25 MHz reference cycles have passed within the current second. The cycle register is coarse: it moves in steps of 16 once every 640 ns, so its four lowest bits always read zero. When it would reach 25,000,000 it returns to zero, and the seconds register goes up by one on the same update. The two values therefore always agree across a second boundary.

A prescaler divides the input clock into an update strobe. With a 25 MHz input and the default divide of 16, there is one strobe every 640 ns. Software reads both registers through one 32-bit request/response port that addresses registers by word index. Each request is answered one cycle later. A write to either register, or any access to an index the block does not decode, is answered with an error flag and changes nothing.

The response path is a three-state machine:
- `RSP_IDLE`: no response.
- `RSP_DATA`: a read was accepted, with valid data.
- `RSP_REJECT`: a write, or an undecoded index; the data reads zero.

On every clock edge the next state comes from the request present in that cycle:
- no request goes to `RSP_IDLE`;
- a write goes to `RSP_REJECT`;
- a read of index 0 or index 1 goes to `RSP_DATA`;
- a read of any other index goes to `RSP_REJECT`.

Every state can move to any of the three in one cycle, so back-to-back requests are each answered in turn.

Top module: `ref_time_counters`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rsp_valid` is 0, and both counters are zero.
- R2: The cycle register changes only on a prescaler strobe, which comes once every `PRESCALE_DIV` clock cycles. Each strobe below the wrap point adds exactly 16 (1 << `STEP_SHIFT`).
- R3: Bits [3:0] of every successful read of the cycle register (index 1) are zero.
- R4: The cycle register never reads `WRAP_LIMIT` or more. The strobe that would bring it to `WRAP_LIMIT` sets it to zero instead.
- R5: The seconds register goes up by one on exactly the strobe that wraps the cycle register, and on no other cycle.
- R6: The seconds register is `SEC_W` bits wide. After all ones it wraps to zero. Reads zero-extend it to 32 bits.
- R7: A read request of index 0 (seconds) or index 1 (cycle count) gives, on the next cycle, `rsp_valid`=1, `rsp_err`=0 and the register value as it stood in the request cycle.
- R8: A write request to any index gives, on the next cycle, `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0. It leaves both counters unchanged.
- R9: A read request of any index other than 0 or 1 gives, on the next cycle, `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0.
- R10: Pulling `rst_n` low in the middle of a run restarts both counters from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_index | input | IDX_W | Word index of the register |
| req_wdata | input | DATA_W | Write data (always discarded) |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | DATA_W | Read data, zero on rejection |

## Verification
The bench shortens the second to a few dozen clock cycles and narrows the seconds register to 4 bits. This lets it read the counters on either side of a second boundary and across a seconds wrap.
- A design that wraps the cycle register one step early or late would return a nonzero cycle count, or the wrong second, right at the boundary reads.
- A seconds counter that moves out of step with the wrap would be off by one there.
- A design that stores writes would return the written pattern on the reads that follow.
- A design that decodes too wide would answer undecoded indices without the error flag.
- A design that samples its data a cycle late would be one strobe ahead on reads taken just before a strobe.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // State of the response path of the register port
    typedef enum logic [1:0] {
        RSP_IDLE   = 2'd0,
        RSP_DATA   = 2'd1,
        RSP_REJECT = 2'd2
    } rsp_state_e;

    // Response flags produced for each state
    typedef struct packed {
        logic valid;
        logic err;
    } rsp_flags_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic strobe_o
);

    generate
        if (DIV <= 1) begin : g_bypass
            assign strobe_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end

            assign strobe_o = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/rtc_subsec_counter.sv
module rtc_subsec_counter #(
    parameter int STEP_SHIFT = 4,
    parameter int WRAP_LIMIT = 25_000_000,
    parameter int CYC_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    output logic             wrap_o,
    output logic [CYC_W-1:0] value_o
);

    // Only the step count is stored; the low bits are always zero.
    localparam int STEPS = WRAP_LIMIT >> STEP_SHIFT;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

    logic [CNT_W-1:0] steps_q;
    logic             at_last;

    assign at_last = (steps_q == LAST_STEP);
    assign wrap_o  = strobe_i && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_q <= '0;
        end else if (strobe_i) begin
            if (at_last) begin
                steps_q <= '0;
            end else begin
                steps_q <= steps_q + CNT_W'(1);
            end
        end
    end

    assign value_o = CYC_W'({steps_q, {STEP_SHIFT{1'b0}}});

endmodule

// File: rtl/rtc_seconds_counter.sv
module rtc_seconds_counter #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [SEC_W-1:0] value_o
);

    logic [SEC_W-1:0] sec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (tick_i) begin
            sec_q <= sec_q + SEC_W'(1);
        end
    end

    assign value_o = sec_q;

endmodule

// File: rtl/rtc_read_port.sv
module rtc_read_port
    import rtc_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int DATA_W  = 32,
    parameter int SEC_IDX = 0,
    parameter int CYC_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] sec_word,
    input  logic [DATA_W-1:0] cyc_word,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [IDX_W-1:0] SEC_SEL = IDX_W'(SEC_IDX);
    localparam logic [IDX_W-1:0] CYC_SEL = IDX_W'(CYC_IDX);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rdata_d;
    rsp_flags_t        flags;
    logic              hit_sec;
    logic              hit_cyc;
    logic              wdata_unused;

    // Write data is discarded by design.
    assign wdata_unused = ^req_wdata;

    assign hit_sec = (req_index == SEC_SEL);
    assign hit_cyc = (req_index == CYC_SEL);

    // Next-state decode of the incoming request
    always_comb begin
        if (!req_valid) begin
            state_d = RSP_IDLE;
        end else if (req_write) begin
            state_d = RSP_REJECT;
        end else if (hit_sec || hit_cyc) begin
            state_d = RSP_DATA;
        end else begin
            state_d = RSP_REJECT;
        end
    end

    always_comb begin
        rdata_d = '0;
        if (state_d == RSP_DATA) begin
            rdata_d = hit_sec ? sec_word : cyc_word;
        end
    end

    // State register, with the data captured in the request cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    // Outputs derived from the current state
    always_comb begin
        flags = '{valid: 1'b0, err: 1'b0};
        unique case (state_q)
            RSP_IDLE:   flags = '{valid: 1'b0, err: 1'b0};
            RSP_DATA:   flags = '{valid: 1'b1, err: 1'b0};
            RSP_REJECT: flags = '{valid: 1'b1, err: 1'b1};
            default:    flags = '{valid: 1'b0, err: 1'b0};
        endcase
    end

    assign rsp_valid = flags.valid;
    assign rsp_err   = flags.err;
    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/ref_time_counters.sv
module ref_time_counters #(
    parameter int PRESCALE_DIV = 16,
    parameter int STEP_SHIFT   = 4,
    parameter int WRAP_LIMIT   = 25_000_000,
    parameter int SEC_W        = 32,
    parameter int DATA_W       = 32,
    parameter int IDX_W        = 4,
    parameter int SEC_IDX      = 0,
    parameter int CYC_IDX      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic              strobe;
    logic              wrap;
    logic [DATA_W-1:0] cyc_value;
    logic [SEC_W-1:0]  sec_value;
    logic [DATA_W-1:0] sec_word;

    rtc_prescaler #(
        .DIV (PRESCALE_DIV)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_o (strobe)
    );

    rtc_subsec_counter #(
        .STEP_SHIFT (STEP_SHIFT),
        .WRAP_LIMIT (WRAP_LIMIT),
        .CYC_W      (DATA_W)
    ) u_subsec (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe),
        .wrap_o   (wrap),
        .value_o  (cyc_value)
    );

    rtc_seconds_counter #(
        .SEC_W (SEC_W)
    ) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (wrap),
        .value_o (sec_value)
    );

    assign sec_word = DATA_W'(sec_value);

    rtc_read_port #(
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W),
        .SEC_IDX (SEC_IDX),
        .CYC_IDX (CYC_IDX)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_index (req_index),
        .req_wdata (req_wdata),
        .sec_word  (sec_word),
        .cyc_word  (cyc_value),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/ref_time_counters_chk.sv
module ref_time_counters_chk #(
    parameter int STEP_SHIFT = 4,
    parameter int WRAP_LIMIT = 25_000_000,
    parameter int SEC_W      = 32,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 4,
    parameter int SEC_IDX    = 0,
    parameter int CYC_IDX    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [IDX_W-1:0]  req_index,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              strobe,
    input logic [DATA_W-1:0] cyc_value,
    input logic [SEC_W-1:0]  sec_value
);

    localparam logic [DATA_W-1:0] LIMIT_V = DATA_W'(WRAP_LIMIT);
    localparam logic [DATA_W-1:0] STEP_V  = DATA_W'(1) << STEP_SHIFT;
    localparam logic [DATA_W-1:0] LAST_V  = LIMIT_V - STEP_V;
    localparam logic [IDX_W-1:0]  SEC_SEL = IDX_W'(SEC_IDX);
    localparam logic [IDX_W-1:0]  CYC_SEL = IDX_W'(CYC_IDX);

    // R1: quiet, zeroed state on leaving reset
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid && cyc_value == '0 && sec_value == '0));

    // R2: no strobe, no movement
    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(cyc_value));

    // R2: one step per strobe below the wrap point
    assert_step_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cyc_value != LAST_V) |=> (cyc_value == $past(cyc_value) + STEP_V));

    // R3: cycle reads have clear low bits
    assert_low_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_index == CYC_SEL) |=>
            (rsp_rdata[STEP_SHIFT-1:0] == '0));

    // R4: never at or above the limit
    assert_below_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_value < LIMIT_V);

    // R5 and R6: wrap and seconds move together; seconds wraps naturally
    assert_wrap_with_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cyc_value == LAST_V) |=>
            (cyc_value == '0 && sec_value == $past(sec_value) + SEC_W'(1)));

    assert_second_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && cyc_value == LAST_V) |=> $stable(sec_value));

    // R7: decoded reads return the value of the request cycle
    assert_read_seconds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_index == SEC_SEL) |=>
            (rsp_valid && !rsp_err && rsp_rdata == DATA_W'($past(sec_value))));

    assert_read_cycles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_index == CYC_SEL) |=>
            (rsp_valid && !rsp_err && rsp_rdata == $past(cyc_value)));

    // R8: writes are rejected with zero data
    assert_write_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

    // R9: undecoded reads are rejected with zero data
    assert_bad_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_index != SEC_SEL && req_index != CYC_SEL) |=>
            (rsp_valid && rsp_err && rsp_rdata == '0));

endmodule

bind ref_time_counters ref_time_counters_chk #(
    .STEP_SHIFT (STEP_SHIFT),
    .WRAP_LIMIT (WRAP_LIMIT),
    .SEC_W      (SEC_W),
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .SEC_IDX    (SEC_IDX),
    .CYC_IDX    (CYC_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_index (req_index),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .strobe    (strobe),
    .cyc_value (cyc_value),
    .sec_value (sec_value)
);

// File: tb/ref_time_counters_tb.sv
module ref_time_counters_tb;

    localparam int DIV     = 4;
    localparam int SHIFT   = 4;
    localparam int LIMIT   = 128;
    localparam int SEC_W   = 4;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 4;
    localparam int STEPS   = LIMIT >> SHIFT;   // strobes per second
    localparam int SEC_MOD = 1 << SEC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [IDX_W-1:0]  req_index = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [DATA_W-1:0] rsp_rdata;

    int  checks = 0;
    int  failures = 0;
    int  edge_cnt = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Edges since reset release, counted by the bench
    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    ref_time_counters #(
        .PRESCALE_DIV (DIV),
        .STEP_SHIFT   (SHIFT),
        .WRAP_LIMIT   (LIMIT),
        .SEC_W        (SEC_W),
        .DATA_W       (DATA_W),
        .IDX_W        (IDX_W),
        .SEC_IDX      (0),
        .CYC_IDX      (1)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_index (req_index),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    // Reference model: register value after k edges since reset
    function automatic logic [DATA_W-1:0] model(input int k, input int idx);
        int st;
        st = k / DIV;
        if (idx == 0) return DATA_W'((st / STEPS) % SEC_MOD);
        if (idx == 1) return DATA_W'((st % STEPS) << SHIFT);
        return '0;
    endfunction

    task automatic check(input string req, input logic [DATA_W+1:0] act,
                         input logic [DATA_W+1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts and ends at a negedge; checks {valid, err, data}
    task automatic access(input string req, input logic wr, input int idx,
                          input logic exp_err);
        int k;
        logic [DATA_W-1:0] exp_data;
        k = edge_cnt;
        exp_data = (exp_err) ? '0 : model(k, idx);
        req_valid = 1'b1;
        req_write = wr;
        req_index = IDX_W'(idx);
        req_wdata = 32'hFFFF_FFF0;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        check(req, {rsp_valid, rsp_err, rsp_rdata}, {1'b1, exp_err, exp_data});
    endtask

    task automatic wait_until(input int n);
        while (edge_cnt < n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [15:0] gap;
        logic        wr;
        logic [3:0]  idx;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   1'b0, 4'd0,  1'b0, 8'd7},   // R7 seconds at start
        '{16'd0,   1'b0, 4'd1,  1'b0, 8'd7},   // R7 cycles at start
        '{16'd3,   1'b0, 4'd1,  1'b0, 8'd2},   // R2 one step later
        '{16'd1,   1'b0, 4'd1,  1'b0, 8'd2},   // R2
        '{16'd5,   1'b0, 4'd1,  1'b0, 8'd3},   // R3
        '{16'd2,   1'b1, 4'd1,  1'b1, 8'd8},   // R8 write cycles
        '{16'd0,   1'b0, 4'd1,  1'b0, 8'd8},   // R8 unchanged after write
        '{16'd1,   1'b1, 4'd0,  1'b1, 8'd8},   // R8 write seconds
        '{16'd0,   1'b0, 4'd0,  1'b0, 8'd8},   // R8 unchanged after write
        '{16'd7,   1'b0, 4'd2,  1'b1, 8'd9},   // R9 index 2
        '{16'd0,   1'b0, 4'd15, 1'b1, 8'd9},   // R9 index 15
        '{16'd20,  1'b0, 4'd0,  1'b0, 8'd5},   // R5
        '{16'd9,   1'b0, 4'd1,  1'b0, 8'd4},   // R4
        '{16'd40,  1'b0, 4'd0,  1'b0, 8'd5},   // R5
        '{16'd600, 1'b0, 4'd0,  1'b0, 8'd6},   // R6 past the seconds wrap
        '{16'd3,   1'b0, 4'd1,  1'b0, 8'd4}    // R4
    };

    initial begin
        repeat (5) @(negedge clk);
        // R1: quiet during reset
        check("R1", {rsp_valid, rsp_err, 32'd0}, 34'd0);
        rst_n = 1'b1;
        check("R1", {rsp_valid, rsp_err, 32'd0}, 34'd0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            repeat (int'(VECS[i].gap)) @(negedge clk);
            access($sformatf("R%0d vec%0d", VECS[i].req, i),
                   VECS[i].wr, int'(VECS[i].idx), VECS[i].err);
        end

        // R3: every cycle read over a stretch has clear low bits
        for (int i = 0; i < 12; i++) begin
            access("R3", 1'b0, 1, 1'b0);
            checks++;
            if (rsp_rdata[3:0] !== 4'd0) begin
                failures++;
                $display("FAIL R3 actual=%h expected=0", rsp_rdata[3:0]);
            end
        end

        // Restart for boundary reads at known edges
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: restarted from zero
        access("R10", 1'b0, 0, 1'b0);
        access("R10", 1'b0, 1, 1'b0);

        // R4 and R5: last step of second 0, then the wrap
        wait_until(31);
        access("R4", 1'b0, 1, 1'b0);   // expects 112
        access("R5", 1'b0, 1, 1'b0);   // edge 32: expects 0
        wait_until(28);
        wait_until(63);
        access("R5", 1'b0, 0, 1'b0);   // expects 1
        access("R5", 1'b0, 0, 1'b0);   // edge 64: expects 2

        // R6: seconds 15 then wrap to 0
        wait_until(511);
        access("R6", 1'b0, 0, 1'b0);   // expects 15
        access("R6", 1'b0, 0, 1'b0);   // expects 0

        // R1: idle cycle shows no response
        @(negedge clk);
        check("R1 idle", {rsp_valid, rsp_err, 32'd0}, 34'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule